// File: doc/BRIEF.md
# Battery Presence Detection Sequencer

This block decides whether a removable battery pack is attached to a charger. It runs a timed two-step probe. First it asks for a small discharge load. Then, after one idle cycle, it asks for a small wake current. It looks at two battery-voltage comparator flags only in the final cycle of each step.

The pack is reported missing only when both tests pass:
- the voltage has collapsed below the short threshold under the discharge load, and
- the voltage has then climbed back above the recharge threshold under the wake current.

While the pack stays missing, the probe repeats without end. If either test fails, a pack is taken to be present. The block then clears its missing indication and issues a single-cycle start-charge request.

During charging, the block waits for a termination event. It then asks for a termination discharge current for a fixed interval, and then watches the recharge flag. When the flag reports that the battery has sagged to the recharge level, the probe starts again.

The probe also starts by itself when reset is released. All interval lengths are parameters in clock cycles. The current sources and the comparators are outside the block.

Top module: `batt_presence_seq`

## Requirements
- R1: While reset is held, every request output, `start_charge` and `bat_absent` are 0. In the first cycle after reset is released, `dis_req` rises and stays high for exactly DIS_CYC cycles.
- R2: If `bat_low_short` is 0 in the last cycle of the discharge step, the discharge test fails. `start_charge` is then high for exactly one cycle, in the next cycle, and no wake step follows.
- R3: If `bat_low_short` is 1 in the last cycle of the discharge step, one cycle with no request follows. Then `wake_req` is high for exactly WAKE_CYC cycles.
- R4: If `bat_below_rch` is 0 in the last cycle of the wake step, `bat_absent` is 1 in the next cycle, which carries no request. In the cycle after that, a new discharge step begins.
- R5: If `bat_below_rch` is 1 in the last cycle of the wake step, the wake test fails. `start_charge` pulses for one cycle and `bat_absent` reads 0 in that same cycle.
- R6: `bat_absent` keeps its value through repeated probes. It falls only in a cycle where `start_charge` is high.
- R7: During a discharge or wake step, flag values in every cycle other than the last one have no effect on the outcome.
- R8: At most one of `dis_req`, `wake_req` and `tdis_req` is high in any cycle. Every rising edge of one of them is preceded by a cycle in which none is high.
- R9: After `start_charge`, the block idles, and during that wait `bat_below_rch` has no effect. A `term_done` pulse makes `tdis_req` rise in the next cycle and stay high for exactly TDIS_CYC cycles. `term_done` has no effect during a probe.
- R10: After the termination discharge, the block idles until it sees `bat_below_rch` at 1. `dis_req` then rises two cycles later. Flag values seen during the termination discharge itself are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a probe |
| bat_low_short | input | 1 | Battery voltage is below the short threshold (2 V per cell) |
| bat_below_rch | input | 1 | Battery voltage is at or below the recharge threshold (100 mV per cell under regulation) |
| term_done | input | 1 | Charge termination has been detected |
| dis_req | output | 1 | Request for the probe discharge load |
| wake_req | output | 1 | Request for the probe wake current |
| tdis_req | output | 1 | Request for the post-termination discharge current |
| start_charge | output | 1 | Single-cycle request to begin a new charge cycle |
| bat_absent | output | 1 | Pack is judged missing |

## Verification
The bench sweeps every pass/fail combination of the two tests, starting from both values of the missing flag. In each step it drives the opposite flag value in all cycles but the last. A design that samples the flag early, or latches it early, therefore reaches the wrong verdict.

Step lengths are counted cycle by cycle. An off-by-one in the interval counter shows up as a discharge, wake or termination step one cycle too long or too short. Missing idle cycles between steps are caught by checking the cycle right after each step.

A design that cleared the missing flag on a passing probe, or kept it set on a failure, is caught by the flag checks around each verdict. So is one that acts on the recharge flag while charging or during the termination discharge, or that honours `term_done` in the middle of a probe.

// File: rtl/batt_presence_pkg.sv
package batt_presence_pkg;

  typedef enum logic [2:0] {
    ST_GAP_D  = 3'd0,  // idle cycle before a discharge step
    ST_DISCH  = 3'd1,  // probe discharge load
    ST_GAP_W  = 3'd2,  // idle cycle before a wake step
    ST_WAKE   = 3'd3,  // probe wake current
    ST_LAUNCH = 3'd4,  // single start-charge cycle
    ST_CHARGE = 3'd5,  // charging, waiting for termination
    ST_TDIS   = 3'd6,  // termination discharge
    ST_WATCH  = 3'd7   // waiting for sag to recharge level
  } bps_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Length of the timed interval belonging to a state, in cycles.
  function automatic int unsigned phase_len(input bps_state_e s, input int unsigned dis_c,
                                            input int unsigned wake_c, input int unsigned tdis_c);
    case (s)
      ST_DISCH: return dis_c;
      ST_WAKE:  return wake_c;
      ST_TDIS:  return tdis_c;
      default:  return 1;
    endcase
  endfunction

  // A present pack holds its voltage under the discharge load.
  function automatic logic disch_test_ok(input logic low_short);
    return low_short;
  endfunction

  // A missing pack lets the output node float up under the wake current.
  function automatic logic wake_test_ok(input logic below_rch);
    return !below_rch;
  endfunction

endpackage

// File: rtl/batt_presence_timer.sv
module batt_presence_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == limit - CNT_W'(1));
endmodule

// File: rtl/batt_presence_judge.sv
module batt_presence_judge
  import batt_presence_pkg::*;
(
  input  bps_state_e state,
  input  logic       last,
  input  logic       low_short,
  input  logic       below_rch,
  output logic       pass_evt,
  output logic       fail_evt
);
  logic in_test;
  logic ok;

  always_comb begin
    in_test = last && ((state == ST_DISCH) || (state == ST_WAKE));
    ok      = (state == ST_DISCH) ? disch_test_ok(low_short) : wake_test_ok(below_rch);
    pass_evt = in_test && ok;
    fail_evt = in_test && !ok;
  end
endmodule

// File: rtl/batt_presence_decode.sv
module batt_presence_decode
  import batt_presence_pkg::*;
(
  input  bps_state_e state,
  output logic       dis_req,
  output logic       wake_req,
  output logic       tdis_req,
  output logic       start_charge
);
  assign dis_req      = (state == ST_DISCH);
  assign wake_req     = (state == ST_WAKE);
  assign tdis_req     = (state == ST_TDIS);
  assign start_charge = (state == ST_LAUNCH);
endmodule

// File: rtl/batt_presence_seq.sv
module batt_presence_seq
  import batt_presence_pkg::*;
#(
  parameter int unsigned DIS_CYC  = 50_000_000,
  parameter int unsigned WAKE_CYC = 25_000_000,
  parameter int unsigned TDIS_CYC = 13_100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bat_low_short,
  input  logic bat_below_rch,
  input  logic term_done,
  output logic dis_req,
  output logic wake_req,
  output logic tdis_req,
  output logic start_charge,
  output logic bat_absent
);
  localparam int unsigned MAX_LEN = max3(DIS_CYC, WAKE_CYC, TDIS_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  bps_state_e       state_q, state_d;
  logic             restart;
  logic             phase_last;
  logic [CNT_W-1:0] limit;
  logic             pass_evt, fail_evt;
  logic             absent_q;
  logic             req_any;

  assign limit   = CNT_W'(phase_len(state_q, DIS_CYC, WAKE_CYC, TDIS_CYC));
  assign restart = (state_d != state_q);

  batt_presence_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .limit   (limit),
    .last    (phase_last)
  );

  batt_presence_judge u_judge (
    .state     (state_q),
    .last      (phase_last),
    .low_short (bat_low_short),
    .below_rch (bat_below_rch),
    .pass_evt  (pass_evt),
    .fail_evt  (fail_evt)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_GAP_D:  state_d = ST_DISCH;
      ST_DISCH:  if (fail_evt) state_d = ST_LAUNCH; else if (pass_evt) state_d = ST_GAP_W;
      ST_GAP_W:  state_d = ST_WAKE;
      ST_WAKE:   if (fail_evt) state_d = ST_LAUNCH; else if (pass_evt) state_d = ST_GAP_D;
      ST_LAUNCH: state_d = ST_CHARGE;
      ST_CHARGE: if (term_done) state_d = ST_TDIS;
      ST_TDIS:   if (phase_last) state_d = ST_WATCH;
      ST_WATCH:  if (bat_below_rch) state_d = ST_GAP_D;
      default:   state_d = ST_GAP_D;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_GAP_D;
      absent_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fail_evt)                              absent_q <= 1'b0;
      else if (pass_evt && state_q == ST_WAKE)   absent_q <= 1'b1;
    end
  end

  assign bat_absent = absent_q;

  batt_presence_decode u_decode (
    .state        (state_q),
    .dis_req      (dis_req),
    .wake_req     (wake_req),
    .tdis_req     (tdis_req),
    .start_charge (start_charge)
  );

  assign req_any = dis_req | wake_req | tdis_req;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dis_req, wake_req, tdis_req})); // R8
  AST_IDLE_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dis_req) || $rose(wake_req) || $rose(tdis_req)) |-> !$past(req_any)); // R8
  AST_WAKE_AFTER_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(dis_req, 2)); // R3
  AST_ABSENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bat_absent) |-> ($past(wake_req) && !$past(bat_below_rch))); // R4
  AST_ABSENT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bat_absent) |-> start_charge); // R6
  AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_charge) |-> ($past(dis_req) || $past(wake_req))); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_charge |=> !start_charge); // R2
  AST_TDIS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdis_req) |-> $past(term_done)); // R9
endmodule

// File: tb/batt_presence_seq_bench.sv
module batt_presence_seq_bench;
  localparam int unsigned DIS_C  = 5;
  localparam int unsigned WAKE_C = 3;
  localparam int unsigned TDIS_C = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bat_low_short = 1'b0;
  logic bat_below_rch = 1'b0;
  logic term_done = 1'b0;
  logic dis_req, wake_req, tdis_req, start_charge, bat_absent;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit exp_absent = 1'b0;

  always #10 clk = ~clk;

  batt_presence_seq #(.DIS_CYC(DIS_C), .WAKE_CYC(WAKE_C), .TDIS_CYC(TDIS_C)) u_batt_presence_seq (
    .clk(clk), .rst_n(rst_n), .bat_low_short(bat_low_short), .bat_below_rch(bat_below_rch),
    .term_done(term_done), .dis_req(dis_req), .wake_req(wake_req), .tdis_req(tdis_req),
    .start_charge(start_charge), .bat_absent(bat_absent)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog cycles=%0d expected<=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic obs();
    @(negedge clk);
  endtask

  // Entered at an observation where dis_req has just risen.
  task automatic detect(input bit short_ok, input bit wake_ok);
    int n;
    n = 0;
    term_done = 1'b1;  // R9: must be ignored during a probe
    while (dis_req && n < 1000) begin
      n++;
      chk(!tdis_req && !wake_req, "R9", "request during discharge", tdis_req, 0);
      bat_low_short = (n == DIS_C) ? short_ok : !short_ok;  // R7 opposite value early
      bat_below_rch = n[0];
      obs();
    end
    chk(n == DIS_C, "R1", "discharge length", n, DIS_C);
    if (!short_ok) begin
      chk(start_charge == 1'b1, "R2", "start_charge after discharge fail", start_charge, 1);
      chk(bat_absent == 1'b0, "R6", "absent cleared on fail", bat_absent, 0);
      exp_absent = 1'b0;
      term_done = 1'b0;
      obs();
      chk(!start_charge && !wake_req, "R2", "single pulse, no wake", start_charge, 0);
      return;
    end
    chk(!dis_req && !wake_req && !start_charge, "R3", "idle gap before wake", wake_req, 0);
    chk(bat_absent == exp_absent, "R6", "absent held mid probe", bat_absent, exp_absent);
    obs();
    chk(wake_req == 1'b1, "R3", "wake start", wake_req, 1);
    n = 0;
    while (wake_req && n < 1000) begin
      n++;
      bat_below_rch = (n == WAKE_C) ? !wake_ok : wake_ok;  // R7
      bat_low_short = n[0];
      obs();
    end
    chk(n == WAKE_C, "R3", "wake length", n, WAKE_C);
    if (wake_ok) begin
      exp_absent = 1'b1;
      chk(bat_absent == 1'b1, "R4", "absent set", bat_absent, 1);
      chk(!dis_req && !start_charge, "R8", "idle gap before repeat", dis_req, 0);
      obs();
      chk(dis_req == 1'b1, "R4", "probe repeats", dis_req, 1);
    end else begin
      chk(start_charge == 1'b1, "R5", "start_charge after wake fail", start_charge, 1);
      chk(bat_absent == 1'b0, "R5", "absent cleared", bat_absent, 0);
      exp_absent = 1'b0;
      term_done = 1'b0;
      obs();
      chk(!start_charge, "R2", "single pulse", start_charge, 0);
    end
  endtask

  // Entered one cycle after start_charge; returns where dis_req has just risen.
  task automatic charge_cycle();
    int n;
    bat_below_rch = 1'b1;
    term_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      obs();
      chk(!dis_req && !tdis_req && !wake_req, "R9", "recharge flag ignored while charging", dis_req, 0);
    end
    term_done = 1'b1;
    obs();
    term_done = 1'b0;
    chk(tdis_req == 1'b1, "R9", "termination discharge start", tdis_req, 1);
    n = 0;
    while (tdis_req && n < 1000) begin
      n++;
      bat_below_rch = (n != TDIS_C);
      obs();
    end
    chk(n == TDIS_C, "R9", "termination discharge length", n, TDIS_C);
    for (int i = 0; i < 3; i++) begin
      chk(!dis_req && !tdis_req, "R10", "idle while watching", dis_req, 0);
      obs();
    end
    bat_below_rch = 1'b1;
    obs();
    bat_below_rch = 1'b0;
    chk(!dis_req, "R10", "gap after recharge sag", dis_req, 0);
    obs();
    chk(dis_req == 1'b1, "R10", "probe restarts", dis_req, 1);
  endtask

  initial begin
    repeat (3) obs();
    chk(!dis_req && !wake_req && !tdis_req && !start_charge && !bat_absent,
        "R1", "outputs in reset", int'(dis_req), 0);
    rst_n = 1'b1;
    obs();
    chk(dis_req == 1'b1, "R1", "probe starts after reset", dis_req, 1);
    detect(1'b1, 1'b1);
    detect(1'b1, 1'b1);
    detect(1'b0, 1'b0);
    charge_cycle();
    detect(1'b1, 1'b0);
    charge_cycle();
    detect(1'b1, 1'b1);
    detect(1'b1, 1'b0);
    charge_cycle();
    detect(1'b1, 1'b1);
    detect(1'b0, 1'b1);
    charge_cycle();
    detect(1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule